// File: doc/BRIEF.md
# Fast Privileged-Entry State Loader

This block models the architectural state change that a fast system call makes when it moves a thread from user privilege to kernel privilege. Software first programs three entry-configuration registers through a simple address/data port: a code-selector register, a kernel stack-pointer register and a kernel instruction-pointer register. The two pointer registers only ever hold canonical addresses. A write that would break this rule is refused and flagged.

When the execution core strobes an entry request, the block checks the fault conditions against the current mode inputs. An undefined-opcode fault takes priority over a general-protection fault. If no fault applies, the block loads the new privilege level, the instruction and stack pointers, the cleared flag bits, the code and stack selectors and their fixed flat-segment descriptor caches, and the shadow-stack and branch-tracking state. All results are registered. They appear after the clock edge that samples the request, together with a single-cycle outcome pulse. A faulting request changes no architectural state.

Top module: `fast_entry_loader`

## Requirements
- R1: Configuration register addresses are 0x174 (code selector), 0x175 (stack pointer) and 0x176 (instruction pointer). cfg_rdata reads the addressed register combinationally, and any other address reads 0. All three registers reset to 0.
- R2: A write to 0x175 or 0x176 whose bits 63 down to VA_W-1 (default VA_W=48) are not all equal is rejected. The register keeps its old value and cfg_err is high for exactly the cycle after the write. The selector register at 0x174 accepts any value.
- R3: An entry request with lock_pfx high gives a one-cycle fault_ud pulse and changes no state. It takes priority over every general-protection cause.
- R4: An entry request with prot_en low, with real_mode high, or with selector bits 15:2 all zero gives a one-cycle fault_gp pulse and changes no state.
- R5: A successful entry gives a one-cycle entry_ok pulse and sets cpl to 0 (cpl resets to 3). rflags_out becomes rflags_in with bit 17 (VM) and bit 9 (IF) cleared and all other bits kept. rflags_out resets to 0x2.
- R6: With lma high, rip and rsp get the full 64-bit register values. With lma low they get bits 31:0, zero-extended.
- R7: cs_sel is the low 16 bits of the selector register ANDed with 0xFFFC. ss_sel is cs_sel plus 8, modulo 2^16.
- R8: The code cache gets base 0 and limit 0xFFFFF. Its attribute word packs type in bits 3:0, S in bit 4, DPL in bits 6:5, P in bit 7, L in bit 8, D/B in bit 9 and G in bit 10. The value is 0x59B with lma high (L=1, D=0) and 0x69B with lma low (L=0, D=1).
- R9: The stack cache gets base 0, limit 0xFFFFF and attribute 0x693 (type 3, S, P, B and G set, DPL 0), in the same packing as R8.
- R10: When sstk_user_en is high, pl3_ssp receives ssp_in. With lma high, bits 63 down to VA_W are first replaced by copies of bit VA_W-1. When sstk_user_en is low, pl3_ssp keeps its value.
- R11: ssp_out becomes 0 when sstk_kern_en is high and ssp_in otherwise. When ibt_kern_en is high, ibt_track becomes 1 (wait for end-branch) and ibt_supp becomes 0. Otherwise they take ibt_track_in and ibt_supp_in.
- R12: An entry request sampled in the same cycle as a configuration write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 12 | Configuration register address |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Read data for cfg_addr |
| cfg_err | output | 1 | Non-canonical write refused (one cycle) |
| entry_req | input | 1 | Entry request strobe |
| lock_pfx | input | 1 | Request carried a lock prefix |
| prot_en | input | 1 | Protection enabled |
| real_mode | input | 1 | Real-address mode |
| lma | input | 1 | Long mode active |
| sstk_user_en | input | 1 | Shadow stack enabled at caller level |
| sstk_kern_en | input | 1 | Shadow stack enabled at level 0 |
| ibt_kern_en | input | 1 | Indirect-branch tracking enabled at level 0 |
| rflags_in | input | 32 | Current flags |
| ssp_in | input | 64 | Current shadow-stack pointer |
| ibt_track_in | input | 1 | Current tracker state |
| ibt_supp_in | input | 1 | Current suppress bit |
| entry_ok | output | 1 | Successful entry (one cycle) |
| fault_gp | output | 1 | General-protection fault (one cycle) |
| fault_ud | output | 1 | Undefined-opcode fault (one cycle) |
| cpl | output | 2 | Current privilege level |
| rflags_out | output | 32 | Flags after entry |
| rip | output | 64 | Instruction pointer |
| rsp | output | 64 | Stack pointer |
| cs_sel | output | 16 | Code selector |
| cs_base | output | 32 | Code cache base |
| cs_limit | output | 20 | Code cache limit |
| cs_attr | output | 11 | Code cache attributes |
| ss_sel | output | 16 | Stack selector |
| ss_base | output | 32 | Stack cache base |
| ss_limit | output | 20 | Stack cache limit |
| ss_attr | output | 11 | Stack cache attributes |
| ssp_out | output | 64 | Shadow-stack pointer after entry |
| pl3_ssp | output | 64 | Saved user shadow-stack pointer |
| ibt_track | output | 1 | Tracker state |
| ibt_supp | output | 1 | Suppress bit |

## Verification
A configuration write and an entry request can be sampled on the same clock edge. The entry must then use the register contents from before that edge. The bench provokes this collision by writing a zero selector while it strobes an entry with a valid selector already loaded. It judges the result by a successful entry whose code selector comes from the old value. A second entry then has to raise a general-protection fault because the new zero value is now in place. The same collision is also driven with a non-canonical pointer write, and the bench checks that the refusal does not disturb the entry.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    localparam int XLEN   = 64;
    localparam int ADDR_W = 12;
    localparam int FLAG_W = 32;
    localparam int SEL_W  = 16;

    localparam logic [ADDR_W-1:0] ADR_SEL = 12'h174;
    localparam logic [ADDR_W-1:0] ADR_SP  = 12'h175;
    localparam logic [ADDR_W-1:0] ADR_IP  = 12'h176;

    localparam int FLAG_VM_BIT = 17;
    localparam int FLAG_IF_BIT = 9;

    localparam logic [SEL_W-1:0] RPL_CLEAR = 16'hFFFC;
    localparam logic [SEL_W-1:0] SS_STEP   = 16'd8;
    localparam logic [19:0]      FLAT_LIM  = 20'hFFFFF;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_GP   = 2'd1,
        FK_UD   = 2'd2
    } fault_kind_e;

    typedef struct packed {
        logic       g;
        logic       db;
        logic       l;
        logic       p;
        logic [1:0] dpl;
        logic       s;
        logic [3:0] typ;
    } seg_attr_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [31:0]      base;
        logic [19:0]      limit;
        seg_attr_t        attr;
    } seg_cache_t;

    function automatic logic [XLEN-1:0] upper_mask(input int unsigned from_bit);
        logic [XLEN-1:0] ones;
        ones = '1;
        return ones << from_bit;
    endfunction

    function automatic logic addr_is_canon(input logic [XLEN-1:0] a,
                                           input int unsigned va_w);
        logic [XLEN-1:0] m;
        m = upper_mask(va_w - 1);
        return ((a & m) == m) || ((a & m) == '0);
    endfunction

    function automatic logic [XLEN-1:0] sext_from(input logic [XLEN-1:0] a,
                                                  input int unsigned va_w);
        logic [XLEN-1:0] m;
        logic [XLEN-1:0] bitsel;
        m = upper_mask(va_w);
        bitsel = a >> (va_w - 1);
        return bitsel[0] ? (a | m) : (a & ~m);
    endfunction

    function automatic seg_cache_t build_code_cache(input logic [SEL_W-1:0] raw,
                                                    input logic long_mode);
        seg_cache_t c;
        c.sel       = raw & RPL_CLEAR;
        c.base      = '0;
        c.limit     = FLAT_LIM;
        c.attr.typ  = 4'd11;
        c.attr.s    = 1'b1;
        c.attr.dpl  = 2'd0;
        c.attr.p    = 1'b1;
        c.attr.l    = long_mode;
        c.attr.db   = ~long_mode;
        c.attr.g    = 1'b1;
        return c;
    endfunction

    function automatic seg_cache_t build_stack_cache(input logic [SEL_W-1:0] code_sel);
        seg_cache_t c;
        c.sel       = code_sel + SS_STEP;
        c.base      = '0;
        c.limit     = FLAT_LIM;
        c.attr.typ  = 4'd3;
        c.attr.s    = 1'b1;
        c.attr.dpl  = 2'd0;
        c.attr.p    = 1'b1;
        c.attr.l    = 1'b0;
        c.attr.db   = 1'b1;
        c.attr.g    = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/fpe_msr_bank.sv
module fpe_msr_bank
    import fpe_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [XLEN-1:0]   wdata,
    output logic [XLEN-1:0]   rdata,
    output logic              wr_err,
    output logic [XLEN-1:0]   sel_q,
    output logic [XLEN-1:0]   sp_q,
    output logic [XLEN-1:0]   ip_q
);

    logic hit_sel, hit_sp, hit_ip;
    logic canon_ok;

    always_comb begin
        hit_sel  = (addr == ADR_SEL);
        hit_sp   = (addr == ADR_SP);
        hit_ip   = (addr == ADR_IP);
        canon_ok = addr_is_canon(wdata, VA_W);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            sp_q   <= '0;
            ip_q   <= '0;
            wr_err <= 1'b0;
        end else begin
            wr_err <= 1'b0;
            if (wr_en) begin
                if (hit_sel) sel_q <= wdata;
                if (hit_sp || hit_ip) begin
                    if (!canon_ok) begin
                        wr_err <= 1'b1;
                    end else if (hit_sp) begin
                        sp_q <= wdata;
                    end else begin
                        ip_q <= wdata;
                    end
                end
            end
        end
    end

    always_comb begin
        if (hit_sel)     rdata = sel_q;
        else if (hit_sp) rdata = sp_q;
        else if (hit_ip) rdata = ip_q;
        else             rdata = '0;
    end

    a_r2_refused_keeps: assert property (@(posedge clk) disable iff (rst)
        wr_err |-> (sp_q == $past(sp_q)) && (ip_q == $past(ip_q)));

    a_r2_pointers_canon: assert property (@(posedge clk) disable iff (rst)
        addr_is_canon(sp_q, VA_W) && addr_is_canon(ip_q, VA_W));

    a_r2_err_single: assert property (@(posedge clk) disable iff (rst)
        wr_err |=> !wr_err || $past(wr_en));

endmodule

// File: rtl/fpe_entry_guard.sv
module fpe_entry_guard
    import fpe_pkg::*;
(
    input  logic             lock_pfx,
    input  logic             prot_en,
    input  logic             real_mode,
    input  logic [SEL_W-1:0] sel_raw,
    output fault_kind_e      kind
);

    logic null_sel;

    always_comb begin
        null_sel = (sel_raw[SEL_W-1:2] == '0);
        if (lock_pfx)
            kind = FK_UD;
        else if (!prot_en || real_mode || null_sel)
            kind = FK_GP;
        else
            kind = FK_NONE;
    end

endmodule

// File: rtl/fpe_arch_state.sv
module fpe_arch_state
    import fpe_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  fault_kind_e       kind,
    input  logic              lma,
    input  logic              sstk_user_en,
    input  logic              sstk_kern_en,
    input  logic              ibt_kern_en,
    input  logic [FLAG_W-1:0] rflags_in,
    input  logic [XLEN-1:0]   ssp_in,
    input  logic              ibt_track_in,
    input  logic              ibt_supp_in,
    input  logic [SEL_W-1:0]  sel_raw,
    input  logic [XLEN-1:0]   sp_cfg,
    input  logic [XLEN-1:0]   ip_cfg,
    output logic              ok_q,
    output logic              gp_q,
    output logic              ud_q,
    output logic [1:0]        cpl_q,
    output logic [FLAG_W-1:0] flags_q,
    output logic [XLEN-1:0]   rip_q,
    output logic [XLEN-1:0]   rsp_q,
    output seg_cache_t        cs_q,
    output seg_cache_t        ss_q,
    output logic [XLEN-1:0]   ssp_q,
    output logic [XLEN-1:0]   pl3_ssp_q,
    output logic              track_q,
    output logic              supp_q
);

    localparam logic [FLAG_W-1:0] FLAGS_RST = 32'h2;
    localparam logic [FLAG_W-1:0] CLR_MASK  =
        ~((FLAG_W'(1) << FLAG_VM_BIT) | (FLAG_W'(1) << FLAG_IF_BIT));

    seg_cache_t      cs_next, ss_next;
    logic [XLEN-1:0] rip_next, rsp_next, saved_ssp;

    always_comb begin
        cs_next  = build_code_cache(sel_raw, lma);
        ss_next  = build_stack_cache(cs_next.sel);
        rip_next = lma ? ip_cfg : {32'h0, ip_cfg[31:0]};
        rsp_next = lma ? sp_cfg : {32'h0, sp_cfg[31:0]};
        saved_ssp = lma ? sext_from(ssp_in, VA_W) : ssp_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q      <= 1'b0;
            gp_q      <= 1'b0;
            ud_q      <= 1'b0;
            cpl_q     <= 2'd3;
            flags_q   <= FLAGS_RST;
            rip_q     <= '0;
            rsp_q     <= '0;
            cs_q      <= '0;
            ss_q      <= '0;
            ssp_q     <= '0;
            pl3_ssp_q <= '0;
            track_q   <= 1'b0;
            supp_q    <= 1'b0;
        end else begin
            ok_q <= 1'b0;
            gp_q <= 1'b0;
            ud_q <= 1'b0;
            if (req) begin
                case (kind)
                    FK_UD: ud_q <= 1'b1;
                    FK_GP: gp_q <= 1'b1;
                    default: begin
                        ok_q    <= 1'b1;
                        cpl_q   <= 2'd0;
                        flags_q <= rflags_in & CLR_MASK;
                        rip_q   <= rip_next;
                        rsp_q   <= rsp_next;
                        cs_q    <= cs_next;
                        ss_q    <= ss_next;
                        if (sstk_user_en) pl3_ssp_q <= saved_ssp;
                        ssp_q   <= sstk_kern_en ? '0 : ssp_in;
                        track_q <= ibt_kern_en ? 1'b1 : ibt_track_in;
                        supp_q  <= ibt_kern_en ? 1'b0 : ibt_supp_in;
                    end
                endcase
            end
        end
    end

    a_r3_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ok_q, gp_q, ud_q}));

    a_r4_fault_no_change: assert property (@(posedge clk) disable iff (rst)
        (gp_q || ud_q) |-> $stable(cpl_q) && $stable(rip_q) && $stable(rsp_q)
                           && $stable(cs_q) && $stable(flags_q));

    a_r5_entry_state: assert property (@(posedge clk) disable iff (rst)
        ok_q |-> (cpl_q == 2'd0) && !flags_q[FLAG_VM_BIT] && !flags_q[FLAG_IF_BIT]);

    a_r7_rpl_zero: assert property (@(posedge clk) disable iff (rst)
        ok_q |-> (cs_q.sel[1:0] == 2'b00) && (ss_q.sel[1:0] == 2'b00));

    a_r8_cs_flat: assert property (@(posedge clk) disable iff (rst)
        ok_q |-> (cs_q.base == '0) && (cs_q.attr.l != cs_q.attr.db));

    a_r11_ibt_wait: assert property (@(posedge clk) disable iff (rst)
        (req && kind == FK_NONE && ibt_kern_en) |=> track_q && !supp_q);

endmodule

// File: rtl/fast_entry_loader.sv
module fast_entry_loader
    import fpe_pkg::*;
#(
    parameter int VA_W = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [11:0] cfg_addr,
    input  logic [63:0] cfg_wdata,
    output logic [63:0] cfg_rdata,
    output logic        cfg_err,
    input  logic        entry_req,
    input  logic        lock_pfx,
    input  logic        prot_en,
    input  logic        real_mode,
    input  logic        lma,
    input  logic        sstk_user_en,
    input  logic        sstk_kern_en,
    input  logic        ibt_kern_en,
    input  logic [31:0] rflags_in,
    input  logic [63:0] ssp_in,
    input  logic        ibt_track_in,
    input  logic        ibt_supp_in,
    output logic        entry_ok,
    output logic        fault_gp,
    output logic        fault_ud,
    output logic [1:0]  cpl,
    output logic [31:0] rflags_out,
    output logic [63:0] rip,
    output logic [63:0] rsp,
    output logic [15:0] cs_sel,
    output logic [31:0] cs_base,
    output logic [19:0] cs_limit,
    output logic [10:0] cs_attr,
    output logic [15:0] ss_sel,
    output logic [31:0] ss_base,
    output logic [19:0] ss_limit,
    output logic [10:0] ss_attr,
    output logic [63:0] ssp_out,
    output logic [63:0] pl3_ssp,
    output logic        ibt_track,
    output logic        ibt_supp
);

    logic [XLEN-1:0] sel_q, sp_q, ip_q;
    fault_kind_e     kind;
    seg_cache_t      cs_q, ss_q;

    fpe_msr_bank #(.VA_W(VA_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .wr_err (cfg_err),
        .sel_q  (sel_q),
        .sp_q   (sp_q),
        .ip_q   (ip_q)
    );

    fpe_entry_guard u_guard (
        .lock_pfx  (lock_pfx),
        .prot_en   (prot_en),
        .real_mode (real_mode),
        .sel_raw   (sel_q[SEL_W-1:0]),
        .kind      (kind)
    );

    fpe_arch_state #(.VA_W(VA_W)) u_state (
        .clk          (clk),
        .rst          (rst),
        .req          (entry_req),
        .kind         (kind),
        .lma          (lma),
        .sstk_user_en (sstk_user_en),
        .sstk_kern_en (sstk_kern_en),
        .ibt_kern_en  (ibt_kern_en),
        .rflags_in    (rflags_in),
        .ssp_in       (ssp_in),
        .ibt_track_in (ibt_track_in),
        .ibt_supp_in  (ibt_supp_in),
        .sel_raw      (sel_q[SEL_W-1:0]),
        .sp_cfg       (sp_q),
        .ip_cfg       (ip_q),
        .ok_q         (entry_ok),
        .gp_q         (fault_gp),
        .ud_q         (fault_ud),
        .cpl_q        (cpl),
        .flags_q      (rflags_out),
        .rip_q        (rip),
        .rsp_q        (rsp),
        .cs_q         (cs_q),
        .ss_q         (ss_q),
        .ssp_q        (ssp_out),
        .pl3_ssp_q    (pl3_ssp),
        .track_q      (ibt_track),
        .supp_q       (ibt_supp)
    );

    always_comb begin
        cs_sel   = cs_q.sel;
        cs_base  = cs_q.base;
        cs_limit = cs_q.limit;
        cs_attr  = cs_q.attr;
        ss_sel   = ss_q.sel;
        ss_base  = ss_q.base;
        ss_limit = ss_q.limit;
        ss_attr  = ss_q.attr;
    end

    a_r3_ud_wins: assert property (@(posedge clk) disable iff (rst)
        (entry_req && lock_pfx) |=> fault_ud && !fault_gp);

    a_r4_gp_on_null: assert property (@(posedge clk) disable iff (rst)
        (entry_req && !lock_pfx && prot_en && !real_mode && cfg_rdata[15:2] == '0
         && cfg_addr == ADR_SEL) |=> fault_gp);

    a_r9_ss_flat: assert property (@(posedge clk) disable iff (rst)
        entry_ok |-> (ss_base == '0) && (ss_limit == 20'hFFFFF) && (ss_attr[3:0] == 4'd3));

endmodule

// File: tb/sim_fast_entry_loader.sv
module sim_fast_entry_loader;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [11:0] cfg_addr;
    logic [63:0] cfg_wdata;
    logic [63:0] cfg_rdata;
    logic        cfg_err;
    logic        entry_req, lock_pfx, prot_en, real_mode, lma;
    logic        sstk_user_en, sstk_kern_en, ibt_kern_en;
    logic [31:0] rflags_in;
    logic [63:0] ssp_in;
    logic        ibt_track_in, ibt_supp_in;
    logic        entry_ok, fault_gp, fault_ud;
    logic [1:0]  cpl;
    logic [31:0] rflags_out;
    logic [63:0] rip, rsp;
    logic [15:0] cs_sel, ss_sel;
    logic [31:0] cs_base, ss_base;
    logic [19:0] cs_limit, ss_limit;
    logic [10:0] cs_attr, ss_attr;
    logic [63:0] ssp_out, pl3_ssp;
    logic        ibt_track, ibt_supp;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fast_entry_loader u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .entry_req(entry_req), .lock_pfx(lock_pfx), .prot_en(prot_en),
        .real_mode(real_mode), .lma(lma), .sstk_user_en(sstk_user_en),
        .sstk_kern_en(sstk_kern_en), .ibt_kern_en(ibt_kern_en),
        .rflags_in(rflags_in), .ssp_in(ssp_in), .ibt_track_in(ibt_track_in),
        .ibt_supp_in(ibt_supp_in), .entry_ok(entry_ok), .fault_gp(fault_gp),
        .fault_ud(fault_ud), .cpl(cpl), .rflags_out(rflags_out), .rip(rip),
        .rsp(rsp), .cs_sel(cs_sel), .cs_base(cs_base), .cs_limit(cs_limit),
        .cs_attr(cs_attr), .ss_sel(ss_sel), .ss_base(ss_base),
        .ss_limit(ss_limit), .ss_attr(ss_attr), .ssp_out(ssp_out),
        .pl3_ssp(pl3_ssp), .ibt_track(ibt_track), .ibt_supp(ibt_supp)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_cfg(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_cfg(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic strobe_entry();
        @(negedge clk);
        entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        chk("R5 reset cpl", 64'(cpl), 64'd3);
        chk("R5 reset flags", 64'(rflags_out), 64'h2);
        rd_cfg(12'h174, d); chk("R1 reset sel", d, 64'h0);
        rd_cfg(12'h176, d); chk("R1 reset ip", d, 64'h0);
    endtask

    task automatic t_msr_rw();
        logic [63:0] d;
        wr_cfg(12'h174, 64'hABCD_0000_0000_0063);
        wr_cfg(12'h175, 64'hFFFF_8000_0000_2000);
        wr_cfg(12'h176, 64'hFFFF_8000_0000_1000);
        rd_cfg(12'h174, d); chk("R1 read sel", d, 64'hABCD_0000_0000_0063);
        rd_cfg(12'h175, d); chk("R1 read sp", d, 64'hFFFF_8000_0000_2000);
        rd_cfg(12'h176, d); chk("R1 read ip", d, 64'hFFFF_8000_0000_1000);
        rd_cfg(12'h177, d); chk("R1 unmapped", d, 64'h0);
    endtask

    task automatic t_canonical();
        logic [63:0] d;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 12'h175; cfg_wdata = 64'h0000_8000_0000_0000;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R2 err pulse", 64'(cfg_err), 64'd1);
        @(negedge clk);
        chk("R2 err one cycle", 64'(cfg_err), 64'd0);
        rd_cfg(12'h175, d); chk("R2 sp kept", d, 64'hFFFF_8000_0000_2000);
        wr_cfg(12'h176, 64'h8000_0000_0000_1000);
        chk("R2 ip err", 64'(cfg_err), 64'd1);
        rd_cfg(12'h176, d); chk("R2 ip kept", d, 64'hFFFF_8000_0000_1000);
        wr_cfg(12'h176, 64'h0000_7FFF_FFFF_F000);
        chk("R2 legal no err", 64'(cfg_err), 64'd0);
        rd_cfg(12'h176, d); chk("R2 legal stored", d, 64'h0000_7FFF_FFFF_F000);
        wr_cfg(12'h176, 64'hFFFF_8000_0000_1000);
    endtask

    task automatic t_faults();
        // lock prefix with a null selector: #UD wins (R3)
        wr_cfg(12'h174, 64'h0);
        lock_pfx = 1'b1;
        strobe_entry();
        chk("R3 ud pulse", 64'(fault_ud), 64'd1);
        chk("R3 no gp", 64'(fault_gp), 64'd0);
        chk("R3 cpl kept", 64'(cpl), 64'd3);
        lock_pfx = 1'b0;
        strobe_entry();
        chk("R4 null sel gp", 64'(fault_gp), 64'd1);
        wr_cfg(12'h174, 64'h3);
        strobe_entry();
        chk("R4 rpl only sel gp", 64'(fault_gp), 64'd1);
        wr_cfg(12'h174, 64'h63);
        prot_en = 1'b0;
        strobe_entry();
        chk("R4 prot off gp", 64'(fault_gp), 64'd1);
        prot_en = 1'b1; real_mode = 1'b1;
        strobe_entry();
        chk("R4 real mode gp", 64'(fault_gp), 64'd1);
        chk("R4 rip kept", rip, 64'h0);
        chk("R4 cs kept", 64'(cs_sel), 64'h0);
        real_mode = 1'b0;
    endtask

    task automatic t_entry64();
        lma = 1'b1; rflags_in = 32'h0002_0A02;
        sstk_user_en = 1'b1; sstk_kern_en = 1'b1; ibt_kern_en = 1'b1;
        ssp_in = 64'h0000_8000_0000_1230;
        ibt_track_in = 1'b0; ibt_supp_in = 1'b1;
        strobe_entry();
        chk("R5 ok pulse", 64'(entry_ok), 64'd1);
        chk("R5 cpl zero", 64'(cpl), 64'd0);
        chk("R5 flags cleared", 64'(rflags_out), 64'h0000_0802);
        chk("R6 rip 64", rip, 64'hFFFF_8000_0000_1000);
        chk("R6 rsp 64", rsp, 64'hFFFF_8000_0000_2000);
        chk("R7 cs sel", 64'(cs_sel), 64'h0060);
        chk("R7 ss sel", 64'(ss_sel), 64'h0068);
        chk("R8 cs attr long", 64'(cs_attr), 64'h59B);
        chk("R8 cs limit", 64'(cs_limit), 64'hFFFFF);
        chk("R8 cs base", 64'(cs_base), 64'h0);
        chk("R9 ss attr", 64'(ss_attr), 64'h693);
        chk("R9 ss limit", 64'(ss_limit), 64'hFFFFF);
        chk("R10 pl3 sext", pl3_ssp, 64'hFFFF_8000_0000_1230);
        chk("R11 ssp zero", ssp_out, 64'h0);
        chk("R11 track wait", 64'(ibt_track), 64'd1);
        chk("R11 supp clear", 64'(ibt_supp), 64'd0);
        @(negedge clk);
        chk("R5 ok one cycle", 64'(entry_ok), 64'd0);
    endtask

    task automatic t_entry32();
        lma = 1'b0; rflags_in = 32'h0000_0246;
        sstk_user_en = 1'b1; sstk_kern_en = 1'b0; ibt_kern_en = 1'b0;
        ssp_in = 64'h1234_0000_8000_0040;
        ibt_track_in = 1'b0; ibt_supp_in = 1'b1;
        wr_cfg(12'h174, 64'hFFFB);
        strobe_entry();
        chk("R6 rip 32", rip, 64'h0000_0000_0000_1000);
        chk("R6 rsp 32", rsp, 64'h0000_0000_0000_2000);
        chk("R8 cs attr legacy", 64'(cs_attr), 64'h69B);
        chk("R7 cs wrap", 64'(cs_sel), 64'hFFF8);
        chk("R7 ss wrap", 64'(ss_sel), 64'h0000);
        chk("R5 if cleared", 64'(rflags_out), 64'h0000_0046);
        chk("R10 pl3 raw", pl3_ssp, 64'h1234_0000_8000_0040);
        chk("R11 ssp pass", ssp_out, 64'h1234_0000_8000_0040);
        chk("R11 track pass", 64'(ibt_track), 64'd0);
        chk("R11 supp pass", 64'(ibt_supp), 64'd1);
        // shadow stack off at caller level: pl3 untouched
        lma = 1'b1; sstk_user_en = 1'b0;
        ssp_in = 64'h0000_0000_0000_5000;
        strobe_entry();
        chk("R10 pl3 kept", pl3_ssp, 64'h1234_0000_8000_0040);
        sstk_user_en = 1'b1;
        ssp_in = 64'h1234_0000_0000_5000;
        strobe_entry();
        chk("R10 pl3 upper cleared", pl3_ssp, 64'h0000_0000_0000_5000);
    endtask

    task automatic t_collision();
        logic [63:0] d;
        wr_cfg(12'h174, 64'h0010);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 12'h174; cfg_wdata = 64'h0;
        entry_req = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; entry_req = 1'b0;
        chk("R12 old sel used ok", 64'(entry_ok), 64'd1);
        chk("R12 old sel value", 64'(cs_sel), 64'h0010);
        strobe_entry();
        chk("R12 new sel faults", 64'(fault_gp), 64'd1);
        wr_cfg(12'h174, 64'h0020);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 12'h176; cfg_wdata = 64'h0100_0000_0000_0000;
        entry_req = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; entry_req = 1'b0;
        chk("R12 err with entry", 64'(cfg_err), 64'd1);
        chk("R12 entry ok", 64'(entry_ok), 64'd1);
        chk("R12 rip from old", rip, 64'hFFFF_8000_0000_1000);
        rd_cfg(12'h176, d); chk("R2 ip kept in collision", d, 64'hFFFF_8000_0000_1000);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        entry_req = 1'b0; lock_pfx = 1'b0; prot_en = 1'b1; real_mode = 1'b0;
        lma = 1'b1; sstk_user_en = 1'b0; sstk_kern_en = 1'b0; ibt_kern_en = 1'b0;
        rflags_in = 32'h2; ssp_in = '0; ibt_track_in = 1'b0; ibt_supp_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_msr_rw();
        t_canonical();
        t_faults();
        wr_cfg(12'h174, 64'hABCD_0000_0000_0063);
        t_entry64();
        t_entry32();
        t_collision();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog all requirements got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule